// File: doc/BRIEF.md
# Stereo I2S Transmitter with Register Control

This block is a master-mode stereo serial audio transmitter. Software programs it through a single-cycle register port. It writes a left sample and then a right sample into two holding registers, and the second write places one stereo frame into a transmit FIFO. A serializer pops the frames, shifts them out MSB first in standard I2S framing, and generates its own bit clock and word select from the system clock through a programmable divider.

Serial activity is gated by four enable bits: global, transmitter, channel and clock. The sample width is picked by a small resolution code, and an unrecognised code is ignored. One interrupt line reports two conditions. The first is a low FIFO level, meaning the fill is at or below a programmable trigger. The second is a sticky overrun, which is set when a frame is pushed into a full FIFO. A dedicated register clears the overrun, and reading it is the only way to do so.

Top module: `i2s_tx_regctl`

## Requirements
- R1: The control register (address 0) holds bit 0 global enable, bit 1 transmitter enable, bit 2 channel enable and bit 3 clock enable. `sck_o`, `ws_o` and `sd_o` are low unless all four bits are set. Clearing the clock or global bit stops the bit clock and word select at 0. The register resets to 0.
- R2: While running, each half period of `sck_o` lasts DIV+1 system clocks, where DIV is the register at address 9 (reset 1). Each word-select half lasts exactly as many bit clocks as the sample width. `ws_o` changes only on a falling `sck_o`.
- R3: The resolution register (address 1, bits 2:0) maps code 2 to 16 bits, code 4 to 24 bits and code 5 to 32 bits. A write of any other code leaves the register unchanged. The reset value is 2.
- R4: `ws_o` is low for the left sample and high for the right sample. The MSB appears one bit clock after each word-select change, data changes only on a falling `sck_o`, and the sample is taken from the low bits of the holding-register write.
- R5: A write to the left register (address 7) followed by a write to the right register (address 8) pushes one frame. The FIFO holds 2^(1+DEPTH_EXP) frames and plays them in push order.
- R6: A right-register write while the FIFO is full drops the frame and sets the overrun flag, which is status bit 5 (status is at address 5).
- R7: Only a read of address 6 clears the overrun flag, and that read returns 0. Reads of other registers leave the flag set.
- R8: The low-level flag (status bit 4) is set while the FIFO fill is at or below the trigger level (address 2). The trigger resets to half the depth.
- R9: A write to address 3 with bit 0 set empties the FIFO. A write to address 3 with bit 0 clear has no effect.
- R10: The mask register (address 4, reset 0x33) uses bit 4 for the low-level source and bit 5 for the overrun source, and a set bit masks its source. Bits 0 and 1 are stored for receive sources. `irq_o` is the OR of the unmasked status flags.
- R11: When a left slot starts and the FIFO is empty, both samples of that frame are sent as zeros and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| irq_o | output | 1 | Interrupt, OR of unmasked flags |

## Verification
The serializer is tried at all three widths, each paired with a different divider value (1 at 16 bits, 0 at 32 bits, 2 at 24 bits). This separates a wrong half-period count from a wrong slot length. Sample words carry non-zero upper bits, which exposes a serializer that picks the wrong bits or misses the one-bit delay. A burst of nine pushes into an eight-deep FIFO, followed by draining it, separates a dropped frame from an overwritten one. Interrupt tests walk the trigger and mask settings across the exact fill boundary to show the at-or-below comparison and each mask bit on its own.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_RES   = 4'd1,
    A_TRIG  = 4'd2,
    A_FLUSH = 4'd3,
    A_MASK  = 4'd4,
    A_STAT  = 4'd5,
    A_OVCLR = 4'd6,
    A_LEFT  = 4'd7,
    A_RIGHT = 4'd8,
    A_DIV   = 4'd9
  } reg_addr_e;

  localparam logic [2:0] RES_16 = 3'd2;
  localparam logic [2:0] RES_24 = 3'd4;
  localparam logic [2:0] RES_32 = 3'd5;

  function automatic logic res_code_ok(input logic [2:0] code);
    return (code == RES_16) || (code == RES_24) || (code == RES_32);
  endfunction

  function automatic logic [5:0] res_bits(input logic [2:0] code);
    case (code)
      RES_16:  return 6'd16;
      RES_24:  return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [CNT_W-1:0] fill,
  input  logic             fifo_full,
  output logic             run,
  output logic [5:0]       width,
  output logic [DIV_W-1:0] div,
  output logic             push,
  output logic [63:0]      push_data,
  output logic             flush,
  output logic             irq,
  output logic             ovr_flag,
  output logic             ovr_clr,
  output logic             mask_empty,
  output logic             mask_ovr
);

  localparam logic [CNT_W-1:0] TRIG_RST = CNT_W'(DEPTH / 2);

  logic [3:0]       ctrl_q, ctrl_d;
  logic [2:0]       res_q, res_d;
  logic [CNT_W-1:0] trig_q, trig_d;
  logic [3:0]       mask_q, mask_d;   // {ovr, low, rx1, rx0}
  logic [DIV_W-1:0] div_q, div_d;
  logic [31:0]      left_q, left_d;
  logic             ovr_q, ovr_d;
  logic             wr_en, rd_en, low_lvl;

  assign wr_en   = reg_sel & reg_wr;
  assign rd_en   = reg_sel & ~reg_wr;
  assign ovr_clr = rd_en && (reg_addr == A_OVCLR);
  assign low_lvl = (fill <= trig_q);

  always_comb begin
    ctrl_d = ctrl_q;
    res_d  = res_q;
    trig_d = trig_q;
    mask_d = mask_q;
    div_d  = div_q;
    left_d = left_q;
    push   = 1'b0;
    flush  = 1'b0;
    if (wr_en) begin
      case (reg_addr_e'(reg_addr))
        A_CTRL:  ctrl_d = reg_wdata[3:0];
        A_RES:   if (res_code_ok(reg_wdata[2:0])) res_d = reg_wdata[2:0];
        A_TRIG:  trig_d = reg_wdata[CNT_W-1:0];
        A_FLUSH: flush = reg_wdata[0];
        A_MASK:  mask_d = {reg_wdata[5:4], reg_wdata[1:0]};
        A_LEFT:  left_d = reg_wdata;
        A_RIGHT: push = 1'b1;
        A_DIV:   div_d = reg_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
    if (push && fifo_full) ovr_d = 1'b1;
    else if (ovr_clr)      ovr_d = 1'b0;
    else                   ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 4'h0;
      res_q  <= RES_16;
      trig_q <= TRIG_RST;
      mask_q <= 4'hF;
      div_q  <= DIV_W'(1);
      left_q <= 32'h0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        ctrl_q <= ctrl_d;
        res_q  <= res_d;
        trig_q <= trig_d;
        mask_q <= mask_d;
        div_q  <= div_d;
        left_q <= left_d;
      end
      ovr_q <= ovr_d;
    end
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = {28'h0, ctrl_q};
      A_RES:   reg_rdata = {29'h0, res_q};
      A_TRIG:  reg_rdata = 32'(trig_q);
      A_MASK:  reg_rdata = {26'h0, mask_q[3:2], 2'b00, mask_q[1:0]};
      A_STAT:  reg_rdata = {26'h0, ovr_q, low_lvl, 4'h0};
      A_DIV:   reg_rdata = 32'(div_q);
      default: reg_rdata = 32'h0;
    endcase
  end

  assign run        = &ctrl_q;
  assign width      = res_bits(res_q);
  assign div        = div_q;
  assign push_data  = {left_q, reg_wdata};
  assign ovr_flag   = ovr_q;
  assign mask_empty = mask_q[2];
  assign mask_ovr   = mask_q[3];
  assign irq        = (low_lvl & ~mask_q[2]) | (ovr_q & ~mask_q[3]);

endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] fill,
  output logic             full,
  output logic             empty
);

  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;

  always_comb begin
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      wp_d  = wp_q + PW'(do_push);
      rp_d  = rp_q + PW'(do_pop);
      cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign head = mem[rp_q];
  assign fill = cnt_q;

endmodule

// File: rtl/i2s_tx_serial.sv
module i2s_tx_serial #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [5:0]       width,
  input  logic [63:0]      head,
  input  logic             fifo_empty,
  output logic             pop,
  output logic             sck_o,
  output logic             ws_o,
  output logic             sd_o
);

  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic             sck_q, sck_d, ws_q, ws_d, sd_q, sd_d;
  logic [5:0]       bit_q, bit_d;
  logic [31:0]      sh_q, sh_d, right_q, right_d;
  logic             tick, fall, slot_end;
  logic [5:0]       pad;

  assign tick     = (dcnt_q == div);
  assign fall     = tick & sck_q;
  assign pad      = 6'd32 - width;
  assign slot_end = (bit_q >= 6'(width - 6'd1));

  always_comb begin
    dcnt_d  = dcnt_q;
    sck_d   = sck_q;
    ws_d    = ws_q;
    sd_d    = sd_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    right_d = right_q;
    pop     = 1'b0;
    if (!run) begin
      dcnt_d  = '0;
      sck_d   = 1'b0;
      ws_d    = 1'b1;
      sd_d    = 1'b0;
      bit_d   = 6'd31;
      sh_d    = '0;
      right_d = '0;
    end else begin
      if (tick) begin
        dcnt_d = '0;
        sck_d  = ~sck_q;
      end else begin
        dcnt_d = dcnt_q + DIV_W'(1);
      end
      if (fall) begin
        sd_d = sh_q[31];
        if (slot_end) begin
          ws_d  = ~ws_q;
          bit_d = '0;
          if (ws_q) begin
            if (!fifo_empty) begin
              pop     = 1'b1;
              sh_d    = head[63:32] << pad;
              right_d = head[31:0];
            end else begin
              sh_d    = '0;
              right_d = '0;
            end
          end else begin
            sh_d = right_q << pad;
          end
        end else begin
          sh_d  = sh_q << 1;
          bit_d = bit_q + 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      sck_q   <= 1'b0;
      ws_q    <= 1'b1;
      sd_q    <= 1'b0;
      bit_q   <= 6'd31;
      sh_q    <= '0;
      right_q <= '0;
    end else begin
      dcnt_q  <= dcnt_d;
      sck_q   <= sck_d;
      ws_q    <= ws_d;
      sd_q    <= sd_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      right_q <= right_d;
    end
  end

  assign sck_o = run & sck_q;
  assign ws_o  = run & ws_q;
  assign sd_o  = run & sd_q;

endmodule

// File: rtl/i2s_tx_regctl.sv
module i2s_tx_regctl #(
  parameter int DEPTH_EXP = 2,
  parameter int DIV_W     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sck_o,
  output logic        ws_o,
  output logic        sd_o,
  output logic        irq_o
);

  localparam int DEPTH = 1 << (DEPTH_EXP + 1);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int FW    = 64;

  logic             run, push, pop, flush;
  logic             fifo_full, fifo_empty;
  logic             ovr_flag, ovr_clr, mask_empty, mask_ovr;
  logic [CNT_W-1:0] fifo_fill;
  logic [5:0]       width;
  logic [DIV_W-1:0] div;
  logic [FW-1:0]    push_data, head;

  i2s_tx_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fill(fifo_fill), .fifo_full(fifo_full),
    .run(run), .width(width), .div(div),
    .push(push), .push_data(push_data), .flush(flush), .irq(irq_o),
    .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
    .mask_empty(mask_empty), .mask_ovr(mask_ovr)
  );

  i2s_tx_fifo #(.DW(FW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .wdata(push_data), .pop(pop), .flush(flush),
    .head(head), .fill(fifo_fill), .full(fifo_full), .empty(fifo_empty)
  );

  i2s_tx_serial #(.DIV_W(DIV_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .run(run), .div(div), .width(width),
    .head(head), .fifo_empty(fifo_empty), .pop(pop),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o)
  );

endmodule

// File: rtl/i2s_tx_regctl_chk.sv
module i2s_tx_regctl_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sck_o,
  input logic             ws_o,
  input logic             sd_o,
  input logic             irq_o,
  input logic             push,
  input logic             pop,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [CNT_W-1:0] fifo_fill,
  input logic             ovr_flag,
  input logic             ovr_clr,
  input logic             mask_empty,
  input logic             mask_ovr
);

  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$past(run)) |-> !sck_o);

  // R2
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(ws_o)) |-> $fell(sck_o));

  // R4
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(sd_o)) |-> $fell(sck_o));

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fill <= CNT_W'(DEPTH));

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(push && fifo_full));

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(ovr_clr));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_empty && mask_ovr) |-> !irq_o);

  // R11
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

endmodule

bind i2s_tx_regctl i2s_tx_regctl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run),
  .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .irq_o(irq_o),
  .push(push), .pop(pop), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .fifo_fill(fifo_fill), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr),
  .mask_empty(mask_empty), .mask_ovr(mask_ovr)
);

// File: tb/tb_i2s_tx_regctl.sv
module tb_i2s_tx_regctl;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, wr;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        sck_o, ws_o, sd_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2s_tx_regctl dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .irq_o(irq_o)
  );

  // ---------------- behavioural reference ----------------
  logic [3:0]  m_ctrl, m_mask;
  logic [2:0]  m_res;
  int          m_trig, m_divreg, m_div, m_bit, w_m;
  logic [31:0] m_left, m_word, m_right;
  bit          m_ovr, m_sck, m_ws, m_sd, fall_m, full_old, pop_m, ws_old;
  logic [63:0] q[$];
  logic [63:0] fr;

  function automatic int width_of(input logic [2:0] c);
    if (c == 3'd2) return 16;
    if (c == 3'd4) return 24;
    return 32;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 4'h0; m_mask = 4'hF; m_res = 3'd2; m_trig = DEPTH / 2;
      m_divreg = 1; m_div = 0; m_bit = 31; m_left = 0; m_word = 0; m_right = 0;
      m_ovr = 0; m_sck = 0; m_ws = 1; m_sd = 0;
      q.delete();
    end else begin
      w_m = width_of(m_res);
      pop_m = 0;
      full_old = (q.size() == DEPTH);
      if (m_ctrl != 4'hF) begin
        m_sck = 0; m_div = 0; m_ws = 1; m_sd = 0; m_bit = 31; m_word = 0; m_right = 0;
      end else begin
        fall_m = (m_div == m_divreg) && m_sck;
        if (m_div == m_divreg) begin m_div = 0; m_sck = !m_sck; end
        else m_div = m_div + 1;
        if (fall_m) begin
          m_sd = m_word[31];
          if (m_bit >= w_m - 1) begin
            ws_old = m_ws;
            m_ws = !m_ws;
            m_bit = 0;
            if (ws_old) begin
              if (q.size() > 0) begin
                fr = q[0]; pop_m = 1;
                m_word = fr[63:32] << (32 - w_m);
                m_right = fr[31:0];
              end else begin
                m_word = 0; m_right = 0;
              end
            end else begin
              m_word = m_right << (32 - w_m);
            end
          end else begin
            m_word = m_word << 1;
            m_bit = m_bit + 1;
          end
        end
      end
      if (pop_m) void'(q.pop_front());
      if (sel && !wr && addr == 4'd6) m_ovr = 0;
      if (sel && wr) begin
        case (addr)
          4'd0: m_ctrl = wdata[3:0];
          4'd1: if (wdata[2:0] == 3'd2 || wdata[2:0] == 3'd4 || wdata[2:0] == 3'd5) m_res = wdata[2:0];
          4'd2: m_trig = int'(wdata[3:0]);
          4'd3: if (wdata[0]) q.delete();
          4'd4: m_mask = {wdata[5:4], wdata[1:0]};
          4'd7: m_left = wdata;
          4'd8: if (full_old) m_ovr = 1; else q.push_back({m_left, wdata});
          4'd9: m_divreg = int'(wdata[7:0]);
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison: R1 R2 R4 R5 R6 R8 R10 R11
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      logic en, e_sck, e_ws, e_sd, e_irq, low;
      en = (m_ctrl == 4'hF);
      e_sck = en & m_sck; e_ws = en & m_ws; e_sd = en & m_sd;
      low = (q.size() <= m_trig);
      e_irq = (low & ~m_mask[2]) | (m_ovr & ~m_mask[3]);
      n_chk++;
      if ({sck_o, ws_o, sd_o, irq_o} !== {e_sck, e_ws, e_sd, e_irq}) begin
        n_fail++;
        $display("FAIL R1 R2 R4 R6 R10 R11 pins {sck,ws,sd,irq} got=%b exp=%b at %0t",
                 {sck_o, ws_o, sd_o, irq_o}, {e_sck, e_ws, e_sd, e_irq}, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic push_frame(input logic [31:0] l, input logic [31:0] r);
    wr_reg(4'd7, l);
    wr_reg(4'd8, r);
  endtask

  task automatic cap_left(input int w, input logic [31:0] exp, input string tag);
    logic [31:0] got = 0;
    @(negedge ws_o);
    @(posedge sck_o);
    for (int i = 0; i < w; i++) begin
      @(posedge sck_o);
      got = {got[30:0], sd_o};
    end
    chk(tag, got, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    int toggles, ones;
    rst_n = 0; sel = 0; wr = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd_reg(4'd0, d); chk("R1 ctrl reset", d, 32'h0);
    rd_reg(4'd1, d); chk("R3 res reset", d, 32'h2);
    rd_reg(4'd2, d); chk("R8 trigger reset", d, 32'h4);
    rd_reg(4'd4, d); chk("R10 mask reset", d, 32'h33);
    rd_reg(4'd5, d); chk("R8 status reset", d, 32'h10);
    chk("R10 irq masked at reset", {31'h0, irq_o}, 32'h0);

    wr_reg(4'd1, 32'h3); rd_reg(4'd1, d); chk("R3 bad code ignored", d, 32'h2);
    wr_reg(4'd1, 32'h4); rd_reg(4'd1, d); chk("R3 code 4 kept", d, 32'h4);
    wr_reg(4'd1, 32'h2);

    // 16-bit stream, DIV=1
    wr_reg(4'd9, 32'h1);
    push_frame(32'h1234_A5C3, 32'h0000_0F0F);
    push_frame(32'h0000_8001, 32'h0000_7FFE);
    push_frame(32'h0000_5555, 32'h0000_AAAA);
    rd_reg(4'd5, d); chk("R8 fill 3 below trigger", d, 32'h10);
    push_frame(32'h0000_0001, 32'h0000_8000);
    rd_reg(4'd5, d); chk("R8 fill 4 at trigger", d, 32'h10);
    push_frame(32'h0000_C001, 32'h0000_3FFC);
    rd_reg(4'd5, d); chk("R8 fill 5 above trigger", d, 32'h00);
    wr_reg(4'd0, 32'hF);
    cap_left(16, 32'h0000_A5C3, "R4 first left 16-bit");
    repeat (900) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); ones += int'(sd_o); end
    chk("R11 empty fifo gives zeros", ones, 0);

    // clock stop checks
    wr_reg(4'd0, 32'h7);
    toggles = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); toggles += int'(sck_o) + int'(ws_o); end
    chk("R1 clock enable cleared stops sck/ws", toggles, 0);
    wr_reg(4'd0, 32'hE);
    toggles = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); toggles += int'(sck_o) + int'(ws_o); end
    chk("R1 global enable cleared stops sck/ws", toggles, 0);

    // 32-bit stream, DIV=0
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h5);
    wr_reg(4'd9, 32'h0);
    push_frame(32'hDEAD_BEEF, 32'h0123_4567);
    wr_reg(4'd0, 32'hF);
    cap_left(32, 32'hDEAD_BEEF, "R4 left 32-bit");
    repeat (300) @(negedge clk);

    // 24-bit stream, DIV=2
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h4);
    wr_reg(4'd9, 32'h2);
    push_frame(32'hFFAB_CDEF, 32'h0055_AA55);
    wr_reg(4'd0, 32'hF);
    cap_left(24, 32'h00AB_CDEF, "R2 R4 left 24-bit");
    repeat (800) @(negedge clk);

    // overrun, trigger, mask
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h2);
    wr_reg(4'd9, 32'h0);
    for (int i = 0; i < 8; i++) push_frame(32'h100 + i, 32'h200 + i);
    rd_reg(4'd5, d); chk("R5 R8 eight frames stored", d, 32'h00);
    wr_reg(4'd2, 32'h8); rd_reg(4'd5, d); chk("R8 fill equals trigger 8", d, 32'h10);
    wr_reg(4'd2, 32'h4);
    push_frame(32'h0000_9999, 32'h0000_9999);
    rd_reg(4'd5, d); chk("R6 overrun on full push", d, 32'h20);
    chk("R10 overrun masked", {31'h0, irq_o}, 32'h0);
    wr_reg(4'd4, 32'h13);
    chk("R10 overrun unmasked raises irq", {31'h0, irq_o}, 32'h1);
    rd_reg(4'd5, d); chk("R7 status read keeps overrun", d, 32'h20);
    rd_reg(4'd6, d); chk("R7 clear register reads zero", d, 32'h0);
    rd_reg(4'd5, d); chk("R7 overrun cleared", d, 32'h00);
    chk("R10 irq drops after clear", {31'h0, irq_o}, 32'h0);

    // drain: the dropped frame must not appear (checked every cycle)
    wr_reg(4'd0, 32'hF);
    cap_left(16, 32'h0000_0100, "R5 oldest frame first");
    repeat (700) @(negedge clk);
    wr_reg(4'd0, 32'h0);
    rd_reg(4'd5, d); chk("R6 drained, dropped frame absent", d, 32'h10);

    // flush
    for (int i = 0; i < 6; i++) push_frame(32'h300 + i, 32'h400 + i);
    wr_reg(4'd3, 32'h0); rd_reg(4'd5, d); chk("R9 flush bit clear no effect", d, 32'h00);
    wr_reg(4'd3, 32'h1); rd_reg(4'd5, d); chk("R9 flush empties", d, 32'h10);
    wr_reg(4'd4, 32'h23);
    chk("R10 low-level source unmasked", {31'h0, irq_o}, 32'h1);
    wr_reg(4'd0, 32'hF);
    repeat (200) @(negedge clk);

    finish_run();
  end

endmodule